// File: doc/BRIEF.md
# CPU Boot Opcode Injector

This block sits beside an 8-bit microprocessor. The processor shares its address and data bus with an external SRAM. The block creates the processor clock and controls its reset release. It then answers every instruction fetch itself until a boot image has been copied into RAM. The block never becomes bus master. It serves a fixed opcode program one byte per read cycle:

- Load the stack pointer.
- For each image word, from the last word back to the first: load HL, then push HL.
- Load HL with the entry address and push it.
- Return, which starts execution at the entry address.

During each served fetch, the block stretches the cycle with WAIT. It also forces the SRAM output enable inactive, so memory stays off the data bus while the block drives the opcode byte. After the return opcode it releases the bus for good and raises a done flag. From then on the processor runs from SRAM.

The boot image, its load address and its entry address are parameters. An image of odd length is padded with one zero byte, which is the no-operation opcode.

Top module: `boot_injector`

## Requirements
- R1: While system reset is asserted, and until the processor reset is released: cpuResetN is 0, waitN is 1, dataDrive is 0, oeForce is 0 and bootDone is 0.
- R2: After system reset, cpuClk makes exactly RESET_PULSES rising edges (default 10) while cpuResetN is low. cpuResetN then rises.
- R3: After cpuResetN rises, cpuClk runs freely with a period of 2*CLK_HALF system cycles (default 32).
- R4: A falling edge on rdN is synchronised through two flops. On the third system clock edge after rdN goes low, waitN goes to 0 and oeForce goes to 1.
- R5: The served byte is on dataOut with dataDrive=1 before waitN returns to 1. After that, dataDrive and oeForce stay at 1 for HOLD_CYC system cycles (default 16), then both go to 0 together.
- R6: The first three bytes served are 0x31, then the low byte and then the high byte of START_ADDR plus the padded image length.
- R7: If IMG_LEN is odd, the image is extended with one 0x00 byte at its end before it is served.
- R8: Image words are served from the highest address down. Image byte i sits at IMG_BYTES[8*i+7:8*i]. Each word is served as 0x21, then the low byte (even index), then the high byte (odd index), then 0xE5.
- R9: After the lowest word, the bytes served are 0x21, the low byte of ENTRY_ADDR, the high byte of ENTRY_ADDR, 0xE5, and last 0xC9.
- R10: Once 0xC9 has been released, bootDone stays at 1. A later falling edge of rdN changes neither waitN, oeForce nor dataDrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| rdN | input | 1 | Processor read strobe, active low, asynchronous |
| cpuClk | output | 1 | Clock driven to the processor |
| cpuResetN | output | 1 | Active-low reset to the processor |
| waitN | output | 1 | Active-low wait request to the processor |
| oeForce | output | 1 | 1 forces the SRAM output enable inactive |
| dataOut | output | 8 | Opcode byte for the data bus |
| dataDrive | output | 1 | 1 enables the data bus drivers for dataOut |
| bootDone | output | 1 | 1 once the final return opcode has been served |

## Verification
Every read result falls at a fixed cycle after rdN drops:

- waitN goes low three system edges later.
- The byte is valid on dataOut with dataDrive high by the fifth edge, which is also when waitN rises.
- dataDrive and oeForce fall HOLD_CYC edges after that.

The bench drives rdN on falling clock edges and counts falling edges until each event. It compares the counts with these numbers, and samples the byte in the cycle where waitN rises. The processor clock is checked in two ways. Rising edges are counted while cpuResetN is low. The period is measured in system cycles between two rising edges seen at falling system edges.

// File: rtl/boot_inj_pkg.sv
package boot_inj_pkg;

  localparam logic [7:0] OP_LD_SP = 8'h31;
  localparam logic [7:0] OP_LD_HL = 8'h21;
  localparam logic [7:0] OP_PUSH  = 8'hE5;
  localparam logic [7:0] OP_RET   = 8'hC9;

  // Which part of the injected program the datapath is serving
  typedef enum logic [1:0] {
    SEG_SP    = 2'd0,
    SEG_IMG   = 2'd1,
    SEG_ENTRY = 2'd2,
    SEG_RET   = 2'd3
  } seg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;  // capture the current program byte onto dataOut
    logic step;   // advance to the next program byte
  } ctrlStrobe_t;

endpackage

// File: rtl/boot_inj_ctrl.sv
module boot_inj_ctrl
  import boot_inj_pkg::*;
#(
  parameter int CLK_HALF     = 16,
  parameter int RESET_PULSES = 10,
  parameter int HOLD_CYC     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rdN,
  input  logic        lastByte,
  output logic        cpuClk,
  output logic        cpuResetN,
  output logic        waitN,
  output logic        oeForce,
  output logic        dataDrive,
  output logic        bootDone,
  output ctrlStrobe_t strobe
);

  localparam int DIV_W   = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam int PULSE_W = $clog2(RESET_PULSES + 1);
  localparam int HCNT_W  = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_GRAB, ST_PRESENT, ST_HOLD, ST_DONE
  } ctrlState_t;

  // ---------------- processor clock and reset sequencing ----------------
  logic [DIV_W-1:0]   divCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               resetDone;
  logic               divTick;

  assign divTick = (divCnt == DIV_W'(CLK_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt    <= '0;
      cpuClk    <= 1'b0;
      pulseCnt  <= '0;
      resetDone <= 1'b0;
    end else begin
      divCnt <= divTick ? '0 : divCnt + 1'b1;
      if (divTick) begin
        cpuClk <= ~cpuClk;
        if (cpuClk && !resetDone) begin
          pulseCnt <= pulseCnt + 1'b1;
          if (pulseCnt == PULSE_W'(RESET_PULSES - 1)) resetDone <= 1'b1;
        end
      end
    end
  end

  assign cpuResetN = resetDone;

  // ---------------- read strobe synchroniser ----------------
  logic rdS1, rdS2, rdPrev, rdFall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdS1   <= 1'b1;
      rdS2   <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      rdS1   <= rdN;
      rdS2   <= rdS1;
      rdPrev <= rdS2;
    end
  end

  assign rdFall = rdPrev & ~rdS2;

  // ---------------- fetch service FSM ----------------
  ctrlState_t        state, stateNxt;
  logic [HCNT_W-1:0] holdCnt;
  logic              holdEnd;

  assign holdEnd = (holdCnt == HCNT_W'(HOLD_CYC - 1));

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_BOOT:    if (resetDone) stateNxt = ST_IDLE;
      ST_IDLE:    if (rdFall) stateNxt = ST_GRAB;
      ST_GRAB:    stateNxt = ST_PRESENT;
      ST_PRESENT: stateNxt = ST_HOLD;
      ST_HOLD:    if (holdEnd) stateNxt = lastByte ? ST_DONE : ST_IDLE;
      ST_DONE:    stateNxt = ST_DONE;
      default:    stateNxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_BOOT;
      holdCnt <= '0;
    end else begin
      state   <= stateNxt;
      holdCnt <= (state == ST_HOLD) ? holdCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    waitN        = !(state == ST_GRAB || state == ST_PRESENT);
    oeForce      = (state == ST_GRAB || state == ST_PRESENT || state == ST_HOLD);
    dataDrive    = (state == ST_PRESENT || state == ST_HOLD);
    bootDone     = (state == ST_DONE);
    strobe.latch = (state == ST_GRAB);
    strobe.step  = (state == ST_HOLD) && holdEnd;
  end

endmodule

// File: rtl/boot_inj_dp.sv
module boot_inj_dp
  import boot_inj_pkg::*;
#(
  parameter int                   IMG_LEN    = 5,
  parameter logic [8*IMG_LEN-1:0] IMG_BYTES  = '0,
  parameter logic [15:0]          START_ADDR = 16'hFF00,
  parameter logic [15:0]          ENTRY_ADDR = 16'hFF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  output logic [7:0]  dataOut,
  output logic        lastByte
);

  localparam int          PAD_LEN    = IMG_LEN + (IMG_LEN % 2);
  localparam int          WORDS      = PAD_LEN / 2;
  localparam int          WIDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [15:0] STACK_INIT = 16'(int'(START_ADDR) + PAD_LEN);

  function automatic logic [7:0] imgByte(input int idx);
    if (idx < IMG_LEN) return IMG_BYTES[idx*8 +: 8];
    return 8'h00;  // padding byte for odd lengths
  endfunction

  seg_t              seg;
  logic [1:0]        phase;
  logic [WIDX_W-1:0] wordIdx;
  logic [7:0]        curByte;

  always_comb begin
    curByte = OP_RET;
    unique case (seg)
      SEG_SP: begin
        unique case (phase)
          2'd0:    curByte = OP_LD_SP;
          2'd1:    curByte = STACK_INIT[7:0];
          default: curByte = STACK_INIT[15:8];
        endcase
      end
      SEG_IMG: begin
        unique case (phase)
          2'd0:    curByte = OP_LD_HL;
          2'd1:    curByte = imgByte(2 * int'(wordIdx));
          2'd2:    curByte = imgByte(2 * int'(wordIdx) + 1);
          default: curByte = OP_PUSH;
        endcase
      end
      SEG_ENTRY: begin
        unique case (phase)
          2'd0:    curByte = OP_LD_HL;
          2'd1:    curByte = ENTRY_ADDR[7:0];
          2'd2:    curByte = ENTRY_ADDR[15:8];
          default: curByte = OP_PUSH;
        endcase
      end
      default: curByte = OP_RET;
    endcase
  end

  assign lastByte = (seg == SEG_RET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg     <= SEG_SP;
      phase   <= '0;
      wordIdx <= WIDX_W'(WORDS - 1);
      dataOut <= '0;
    end else begin
      if (strobe.latch) dataOut <= curByte;
      if (strobe.step) begin
        unique case (seg)
          SEG_SP: begin
            if (phase == 2'd2) begin
              seg   <= SEG_IMG;
              phase <= '0;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          SEG_IMG: begin
            if (phase == 2'd3) begin
              phase <= '0;
              if (wordIdx == '0) seg <= SEG_ENTRY;
              else wordIdx <= wordIdx - 1'b1;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          SEG_ENTRY: begin
            if (phase == 2'd3) begin
              seg   <= SEG_RET;
              phase <= '0;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          default: seg <= SEG_RET;
        endcase
      end
    end
  end

endmodule

// File: rtl/boot_injector.sv
module boot_injector
  import boot_inj_pkg::*;
#(
  parameter int                   IMG_LEN      = 5,
  parameter logic [8*IMG_LEN-1:0] IMG_BYTES    = 40'h76_00_D3_48_3E,
  parameter logic [15:0]          START_ADDR   = 16'hFF00,
  parameter logic [15:0]          ENTRY_ADDR   = 16'hFF02,
  parameter int                   CLK_HALF     = 16,
  parameter int                   RESET_PULSES = 10,
  parameter int                   HOLD_CYC     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdN,
  output logic       cpuClk,
  output logic       cpuResetN,
  output logic       waitN,
  output logic       oeForce,
  output logic [7:0] dataOut,
  output logic       dataDrive,
  output logic       bootDone
);

  ctrlStrobe_t strobe;
  logic        lastByte;

  boot_inj_ctrl #(
    .CLK_HALF(CLK_HALF), .RESET_PULSES(RESET_PULSES), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdN(rdN), .lastByte(lastByte),
    .cpuClk(cpuClk), .cpuResetN(cpuResetN), .waitN(waitN), .oeForce(oeForce),
    .dataDrive(dataDrive), .bootDone(bootDone), .strobe(strobe)
  );

  boot_inj_dp #(
    .IMG_LEN(IMG_LEN), .IMG_BYTES(IMG_BYTES),
    .START_ADDR(START_ADDR), .ENTRY_ADDR(ENTRY_ADDR)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .dataOut(dataOut), .lastByte(lastByte)
  );

endmodule

// File: rtl/boot_injector_chk.sv
module boot_injector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpuResetN,
  input logic       waitN,
  input logic       oeForce,
  input logic [7:0] dataOut,
  input logic       dataDrive,
  input logic       bootDone
);

  assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuResetN |-> (waitN && !dataDrive && !oeForce && !bootDone));

  assert_wait_takes_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(waitN) |-> oeForce && !dataDrive);

  assert_drive_under_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dataDrive |-> oeForce);

  assert_byte_before_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waitN) |-> dataDrive);

  assert_byte_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dataDrive && $past(dataDrive)) |-> $stable(dataOut));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bootDone |=> bootDone);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bootDone |-> (waitN && !oeForce && !dataDrive));

endmodule

bind boot_injector boot_injector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpuResetN(cpuResetN), .waitN(waitN),
  .oeForce(oeForce), .dataOut(dataOut), .dataDrive(dataDrive), .bootDone(bootDone)
);

// File: tb/sim_boot_injector.sv
`timescale 1ns/1ps
module sim_boot_injector;

  localparam int HOLD = 16;
  localparam int NSEQ = 20;
  // image 3E 48 D3 00 76 (+ pad 00), start FF00, entry FF02
  localparam logic [7:0] EXP [NSEQ] = '{
    8'h31, 8'h06, 8'hFF,
    8'h21, 8'h76, 8'h00, 8'hE5,
    8'h21, 8'hD3, 8'h00, 8'hE5,
    8'h21, 8'h3E, 8'h48, 8'hE5,
    8'h21, 8'h02, 8'hFF, 8'hE5,
    8'hC9};

  logic clk = 1'b0, rst_n = 1'b0, rdN = 1'b1;
  logic cpuClk, cpuResetN, waitN, oeForce, dataDrive, bootDone;
  logic [7:0] dataOut;

  int checks = 0, fails = 0, cyc = 0, resetPulses = 0;

  always #2.5 clk = ~clk;

  boot_injector u0 (
    .clk(clk), .rst_n(rst_n), .rdN(rdN), .cpuClk(cpuClk), .cpuResetN(cpuResetN),
    .waitN(waitN), .oeForce(oeForce), .dataOut(dataOut), .dataDrive(dataDrive),
    .bootDone(bootDone)
  );

  always @(posedge cpuClk) if (!cpuResetN) resetPulses++;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string tagOf(input int k);
    if (k < 3) return "R6";
    if (k == 5) return "R7";
    if (k < 15) return "R8";
    return "R9";
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, lo, period;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", cpuResetN, 0, "cpuResetN in reset");
    check("R1", waitN, 1, "waitN in reset");
    check("R1", dataDrive, 0, "dataDrive in reset");
    check("R1", oeForce, 0, "oeForce in reset");
    check("R1", bootDone, 0, "bootDone in reset");
    rst_n = 1'b1;
    // rdN activity before processor reset release is ignored (R1)
    @(negedge clk); rdN = 1'b0;
    repeat (6) @(negedge clk);
    check("R1", waitN, 1, "waitN before cpu reset release");
    rdN = 1'b1;
    while (!cpuResetN) @(negedge clk);
    check("R2", resetPulses, 10, "cpu clock pulses in reset");
    // R3: period
    while (cpuClk) @(negedge clk);
    while (!cpuClk) @(negedge clk);
    period = 0;
    lo = 0;
    while (!(lo == 1 && cpuClk)) begin
      @(negedge clk);
      period++;
      if (!cpuClk) lo = 1;
    end
    check("R3", period, 32, "cpu clock period");

    // vector walk: one fetch per expected byte
    for (int k = 0; k < NSEQ; k++) begin
      @(negedge clk); rdN = 1'b0;
      n = 0;
      while (waitN && n < 50) begin @(negedge clk); n++; end
      check("R4", n, 3, $sformatf("wait latency byte %0d", k));
      check("R4", oeForce, 1, $sformatf("oeForce at wait byte %0d", k));
      n = 0;
      while (!waitN && n < 50) begin @(negedge clk); n++; end
      check("R5", n, 2, $sformatf("wait length byte %0d", k));
      check("R5", dataDrive, 1, $sformatf("drive at release byte %0d", k));
      check(tagOf(k), dataOut, EXP[k], $sformatf("byte %0d", k));
      rdN = 1'b1;
      n = 0;
      while (dataDrive && n < 50) begin @(negedge clk); n++; end
      check("R5", n, HOLD, $sformatf("hold length byte %0d", k));
      check("R5", oeForce, 0, $sformatf("oeForce after hold byte %0d", k));
      repeat (4) @(negedge clk);
    end

    // R10: done and further reads ignored
    check("R10", bootDone, 1, "bootDone after return");
    rdN = 1'b0;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!waitN || dataDrive || oeForce) n++;
    end
    rdN = 1'b1;
    check("R10", n, 0, "cycles with bus activity after done");
    check("R10", bootDone, 1, "bootDone sticky");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule